// File: doc/BRIEF.md
# MAC Interrupt Event and Mask Controller

This block collects single-cycle event pulses from an Ethernet MAC (ECC faults, FIFO overflow and underflow, magic-packet wake, link and fault indications) into a sticky 32-bit event register. Software clears that register one bit at a time by writing ones. A separate 32-bit mask register holds enables for four causes only. Each enable bit sits exactly 16 positions above the event bit it governs. From the pending causes that are enabled, the block drives two registered interrupt lines: one for the three ECC error causes and one for the magic-packet notification.

Software reaches both registers through a plain register port. A write lands on the next rising edge, and a read returns the selected register in the same cycle. There is no handshake: every access completes in one cycle and the port never stalls. The event inputs are plain pulses, not a stream. A pulse is captured in the cycle it is high, and there is no back-pressure on it.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset the event register reads 0x00000000, the mask register reads 0x63000000 (bits 30, 29, 25 and 24 set), and both interrupt lines are low.
- R2: A pulse on event input bit 0, 1, 2, 4 to 14, 29, 30 or 31 sets that event bit on the next rising edge. The bit stays set until software clears it. Event bits 3 and 15 to 28 always read 0, whatever the pulses.
- R3: When wr_en=1 and wr_sel=0, every event bit whose wr_data bit is 1 is cleared, and bits written with 0 keep their value. Writing 0xFFFFFFFF clears every pending event.
- R4: When wr_en=1 and wr_sel=1, only mask bits 30, 29, 25 and 24 take the written value. All other mask bits ignore the write and read 0.
- R5: err_irq is high when at least one of these pairs is set: event bit 13 with mask bit 29, event bit 9 with mask bit 25, or event bit 8 with mask bit 24.
- R6: nrm_irq is high when event bit 14 and mask bit 30 are both set.
- R7: No event bit other than 14, 13, 9 and 8 can raise either interrupt line.
- R8: When a pulse and a write-one-to-clear hit the same event bit in the same cycle, the bit ends up set.
- R9: Both interrupt lines are registered. They follow the event and mask registers one cycle later: a line rises one cycle after the event bit becomes visible, and drops in the cycle after the last enabled pending bit is cleared or masked.
- R10: rd_data shows the event register when rd_sel=0 and the mask register when rd_sel=1, in the same cycle, without side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 32 | Single-cycle event pulses, one per event bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 event (write one to clear), 1 mask |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 event, 1 mask |
| rd_data | output | 32 | Read data of the selected register |
| err_irq | output | 1 | Error interrupt (ECC causes) |
| nrm_irq | output | 1 | Normal interrupt (magic packet) |

## Verification
Suppose an event bit is lost, sticks, or sits in the wrong position. It shows on rd_data in the cycle right after the pulse or the clear write, and it shows on the interrupt lines one cycle after that. The same holds for an enable bit decoded at the wrong offset or a cause routed to the wrong line. The bench therefore sweeps a single pulse through all 32 event positions. It runs every one of the 16 enable combinations against the four maskable causes and checks both lines. It also checks the same-cycle set/clear collision and the one-cycle lag of the lines after a clear or a mask change.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int REG_W    = 32;
  localparam int EN_SHIFT = 16;
  typedef logic [REG_W-1:0] reg_t;

  // event positions that exist in hardware
  localparam reg_t IMPL_BITS    = 32'hE000_7FF7;
  // enable bits the mask register keeps
  localparam reg_t MASKABLE     = 32'h6300_0000;
  // causes feeding the error line (timestamp ECC, Tx ECC, Rx ECC)
  localparam reg_t ERR_CAUSES   = 32'h0000_2300;
  // causes feeding the normal line (magic packet)
  localparam reg_t NRM_CAUSES   = 32'h0000_4000;
  localparam reg_t MASK_RST_VAL = MASKABLE;

  function automatic reg_t enabled_pending(reg_t evt, reg_t msk);
    return evt & ((msk & MASKABLE) >> EN_SHIFT);
  endfunction
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank
  import irq_evt_pkg::*;
#(
  parameter int   W    = REG_W,
  parameter reg_t IMPL = IMPL_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i[i] | (q & ~clr_i[i]);
      end
      assign evt_o[i] = q;
    end else begin : g_tie
      assign evt_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_evt_pkg::*;
#(
  parameter int   W       = REG_W,
  parameter reg_t KEEP    = MASKABLE,
  parameter reg_t RST_VAL = MASK_RST_VAL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST_VAL & KEEP;
    else if (we_i) q <= wdata_i & KEEP;
  end
  assign mask_o = q;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t evt_i,
  input  reg_t mask_i,
  output logic err_o,
  output logic nrm_o
);
  reg_t pend;
  logic err_q, nrm_q;

  assign pend = enabled_pending(evt_i, mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      nrm_q <= 1'b0;
    end else begin
      err_q <= |(pend & ERR_CAUSES);
      nrm_q <= |(pend & NRM_CAUSES);
    end
  end

  assign err_o = err_q;
  assign nrm_o = nrm_q;
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_pulse,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             err_irq,
  output logic             nrm_irq
);
  reg_t evt_q, mask_q, clr_vec;

  assign clr_vec = (wr_en && !wr_sel) ? wr_data : '0;

  irq_evt_bank #(.W(REG_W), .IMPL(IMPL_BITS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_pulse),
    .clr_i (clr_vec),
    .evt_o (evt_q)
  );

  irq_mask_reg #(.W(REG_W), .KEEP(MASKABLE), .RST_VAL(MASK_RST_VAL)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en && wr_sel),
    .wdata_i (wr_data),
    .mask_o  (mask_q)
  );

  irq_line_gen u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_q),
    .mask_i (mask_q),
    .err_o  (err_irq),
    .nrm_o  (nrm_irq)
  );

  assign rd_data = rd_sel ? mask_q : evt_q;
endmodule

// File: rtl/irq_evt_ctrl_chk.sv
module irq_evt_ctrl_chk
  import irq_evt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input reg_t evt_pulse,
  input logic wr_en,
  input logic wr_sel,
  input reg_t wr_data,
  input logic err_irq,
  input logic nrm_irq,
  input reg_t evt_q,
  input reg_t mask_q
);
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R2

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~IMPL_BITS) == '0); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && evt_pulse == '0) |=> ((evt_q & $past(wr_data)) == '0)); // R3

  AST_MASK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~MASKABLE) == '0); // R4

  AST_ERR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_irq == $past((evt_q[13] & mask_q[29]) | (evt_q[9] & mask_q[25]) |
                              (evt_q[8] & mask_q[24])))); // R5

  AST_NRM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nrm_irq == $past(evt_q[14] & mask_q[30]))); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((evt_q & $past(evt_pulse & IMPL_BITS)) ==
                           $past(evt_pulse & IMPL_BITS))); // R8
endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .err_irq   (err_irq),
  .nrm_irq   (nrm_irq),
  .evt_q     (evt_q),
  .mask_q    (mask_q)
);

// File: tb/sim_irq_evt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err_irq, nrm_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // positions from R2, written out independently
  localparam logic [31:0] EXP_IMPL = 32'h8000_0000 | 32'h4000_0000 | 32'h2000_0000 |
                                     32'h0000_7FF0 | 32'h0000_0007;

  irq_evt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .err_irq(err_irq), .nrm_irq(nrm_irq)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_evt();
    return rd_data;
  endfunction

  task automatic read(logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic pulse(logic [31:0] v);
    evt_pulse = v;
    tick();
    evt_pulse = '0;
  endtask

  task automatic wr(logic sel, logic [31:0] v);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read(1'b0, v); check("R1 event", v, 32'h0);
    read(1'b1, v); check("R1 mask", v, 32'h6300_0000);
    check("R1 err", {31'b0, err_irq}, 32'h0);
    check("R1 nrm", {31'b0, nrm_irq}, 32'h0);

    // R2/R3/R5/R6/R9 sweep over every event position, default mask
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      logic e_err, e_nrm;
      b = 32'(1) << i;
      e_err = (i == 13) || (i == 9) || (i == 8);
      e_nrm = (i == 14);
      pulse(b);
      read(1'b0, v); check("R2 set", v, b & EXP_IMPL);
      check("R9 err lags", {31'b0, err_irq}, 32'h0);
      tick();
      read(1'b0, v); check("R2 sticky", v, b & EXP_IMPL);
      check("R5 err", {31'b0, err_irq}, {31'b0, e_err});
      check("R6 nrm", {31'b0, nrm_irq}, {31'b0, e_nrm});
      wr(1'b0, ~b);
      read(1'b0, v); check("R3 zero-write keeps", v, b & EXP_IMPL);
      wr(1'b0, b);
      read(1'b0, v); check("R3 clear", v, 32'h0);
      check("R9 err held", {31'b0, err_irq}, {31'b0, e_err});
      tick();
      check("R9 err drop", {31'b0, err_irq}, 32'h0);
      check("R9 nrm drop", {31'b0, nrm_irq}, 32'h0);
    end

    // R4/R5/R6 all enable combinations against the four maskable causes
    for (int m = 0; m < 16; m++) begin
      logic [31:0] mv;
      mv = (m[3] ? 32'h4000_0000 : 0) | (m[2] ? 32'h2000_0000 : 0) |
           (m[1] ? 32'h0200_0000 : 0) | (m[0] ? 32'h0100_0000 : 0);
      wr(1'b1, mv | 32'h9CFF_FFFF);
      read(1'b1, v); check("R4 mask keeps four bits", v, mv);
      pulse(32'h0000_6300);
      tick();
      check("R5 err combo", {31'b0, err_irq}, {31'b0, m[2] | m[1] | m[0]});
      check("R6 nrm combo", {31'b0, nrm_irq}, {31'b0, m[3]});
      wr(1'b0, 32'hFFFF_FFFF);
      read(1'b0, v); check("R3 all-ones clear", v, 32'h0);
      tick();
      check("R9 err after clear", {31'b0, err_irq}, 32'h0);
    end

    // R7 other causes never reach a line
    wr(1'b1, 32'h6300_0000);
    pulse(~32'h0000_6300);
    tick(); tick();
    check("R7 err quiet", {31'b0, err_irq}, 32'h0);
    check("R7 nrm quiet", {31'b0, nrm_irq}, 32'h0);
    read(1'b0, v); check("R2 all others", v, EXP_IMPL & ~32'h0000_6300);
    wr(1'b0, 32'hFFFF_FFFF);

    // R8 set wins over same-cycle clear
    evt_pulse = 32'h0000_0200;
    wr(1'b0, 32'h0000_0200);
    evt_pulse = '0;
    read(1'b0, v); check("R8 set wins", v, 32'h0000_0200);
    wr(1'b0, 32'hFFFF_FFFF);

    // R9 masking a pending cause drops the line one cycle later, event kept
    pulse(32'h0000_2000);
    tick();
    check("R5 ts ecc err", {31'b0, err_irq}, 32'h1);
    wr(1'b1, 32'h0);
    check("R9 mask lag", {31'b0, err_irq}, 32'h1);
    tick();
    check("R9 masked drop", {31'b0, err_irq}, 32'h0);
    read(1'b0, v); check("R10 event read", v, 32'h0000_2000);
    read(1'b1, v); check("R10 mask read", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule